// File: doc/BRIEF.md
# Redundant SAR Control Sequencer

This block is the digital controller that steps a coarse successive-approximation conversion built on non-binary, redundant capacitor weights. On a start strobe it opens a sample window, then runs eight comparator-driven bit cycles that together resolve seven effective bits. The switching is monotonic: each decision grounds exactly one capacitor of the bit under test, on the positive or the negative side depending on the comparator result. The weights, most significant first, are 480, 256, 128, 64, 40, 24, 16 and 8 units; the control sequence does not depend on them, but the surrounding array does.

After the final bit cycle the controller raises a level-shift control that moves the residue into the middle half of the fine quantizer's range. In the same cycle it powers up the continuous-time comparator. It then waits a programmable settle interval and issues a one-cycle start pulse to the fine stage. It keeps the fine comparator powered for a fixed fine-conversion window and then powers it down again. The raw decision bits stay stable until the next sample phase, so a downstream correction stage can read them at any time.

Top module: `sar_redund_seq`

## Requirements
- R1: A start pulse seen while idle opens a sample phase in the following cycle. In that phase `smp_en` is high for exactly SAMPLE_CYC cycles, and `raw_bits`, `cap_p`, `cap_n` and `lvl_shift` all read 0.
- R2: After the sample phase there are exactly eight bit cycles, marked by `cmp_fire` high. They resolve bit 7 (weight 480) first and bit 0 (weight 8) last.
- R3: A bit cycle ends on the first cycle in which `cmp_rdy` is high. `raw_bits[i]` then takes `cmp_dec`. A 1 sets `cap_p[i]` and a 0 sets `cap_n[i]`.
- R4: If `cmp_rdy` has not arrived after TO_CYC cycles of a bit cycle, that bit is resolved as 0, which grounds `cap_n[i]`. If `cmp_rdy` arrives in the last allowed cycle, its decision is used.
- R5: No bit ever has both `cap_p` and `cap_n` set. Within a conversion, set switch controls never clear, and at most one new switch control is set per cycle.
- R6: In the cycle after the last bit decision, `lvl_shift` and `ct_en` go high. `lvl_shift` stays high until the next start is accepted.
- R7: `fine_go` rises exactly `settle_cycles`+1 cycles after `lvl_shift` rises and lasts one cycle.
- R8: `ct_en` is low during the sample phase and the bit cycles. After the `fine_go` cycle it stays high for exactly FINE_CYC cycles and then falls.
- R9: `raw_bits` holds its value from the end of the last bit cycle until the next sample phase.
- R10: A start pulse during a conversion has no effect.
- R11: `cmp_dec` is ignored in any cycle in which `cmp_rdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion start / sample strobe |
| settle_cycles | input | SETTLE_W | Settle wait after level shift, in cycles minus one |
| cmp_rdy | input | 1 | Coarse comparator decision valid |
| cmp_dec | input | 1 | Coarse comparator decision (1 = positive side higher) |
| smp_en | output | 1 | Sample phase active |
| cmp_fire | output | 1 | Bit cycle active, comparator requested |
| cap_p | output | NBITS | Positive-side switch controls, 1 = grounded |
| cap_n | output | NBITS | Negative-side switch controls, 1 = grounded |
| raw_bits | output | NBITS | Raw redundant decision bits, bit 7 = MSB |
| lvl_shift | output | 1 | Level-shift switch control |
| fine_go | output | 1 | One-cycle fine quantizer start |
| ct_en | output | 1 | Continuous-time comparator power enable |

## Verification
The bench models a differential residue over the redundant weights and answers each comparator request after a chosen latency. The decisions therefore follow a real successive approximation, and an error in bit ordering or in the choice of side shows up as a wrong code. Full-scale positive, full-scale negative and zero inputs separate the dec=1 and dec=0 switch paths. A run in which every request goes unanswered, and one in which every reply comes in the last allowed cycle, probe the two sides of the timeout boundary. Settle values 0 and the maximum check the handoff count, a start pulse in mid-conversion checks that it is ignored, and random inputs with random latencies cover the mixed cases.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    localparam int NB_DEF = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAMP,
        ST_BIT,
        ST_SETL,
        ST_FIRE,
        ST_FINE
    } seq_st_e;

    // one resolved decision from the bit timer
    typedef struct packed {
        logic take;
        logic val;
    } dec_t;

    // redundant capacitor weight in units, indexed from the LSB side
    function automatic int unsigned bit_weight(input int unsigned i);
        case (i)
            0:       return 8;
            1:       return 16;
            2:       return 24;
            3:       return 40;
            4:       return 64;
            5:       return 128;
            6:       return 256;
            default: return 480;
        endcase
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sar_bit_timer.sv
module sar_bit_timer
    import sar_seq_pkg::*;
#(
    parameter int TO_CYC = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic cmp_rdy,
    input  logic cmp_dec,
    output dec_t dec_o
);
    localparam int TW = $clog2(TO_CYC) + 1;

    logic [TW-1:0] wait_q;

    always_comb begin
        dec_o.take = active & (cmp_rdy | (wait_q == TW'(TO_CYC - 1)));
        dec_o.val  = active & cmp_rdy & cmp_dec;
    end

    always_ff @(posedge clk) begin
        if (rst || !active || dec_o.take) wait_q <= '0;
        else                              wait_q <= wait_q + 1'b1;
    end
endmodule

// File: rtl/sar_bit_bank.sv
module sar_bit_bank
    import sar_seq_pkg::*;
#(
    parameter int NBITS = 8,
    localparam int IDX_W = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  dec_t             dec_i,
    input  logic [IDX_W-1:0] idx,
    output logic [NBITS-1:0] raw_q,
    output logic [NBITS-1:0] capp_q,
    output logic [NBITS-1:0] capn_q
);
    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                raw_q[i]  <= 1'b0;
                capp_q[i] <= 1'b0;
                capn_q[i] <= 1'b0;
            end else if (dec_i.take && (idx == IDX_W'(i))) begin
                raw_q[i]  <= dec_i.val;
                capp_q[i] <= dec_i.val;
                capn_q[i] <= ~dec_i.val;
            end
        end
    end
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int NBITS      = 8,
    parameter int SAMPLE_CYC = 4,
    parameter int FINE_CYC   = 8,
    parameter int SETTLE_W   = 4,
    localparam int IDX_W     = $clog2(NBITS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                take,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output seq_st_e             st_q,
    output logic [IDX_W-1:0]    idx_q,
    output logic                clr,
    output logic                lvl_q
);
    localparam int CNT_W = $clog2(max3(SAMPLE_CYC, FINE_CYC, 1 << SETTLE_W)) + 1;

    logic [CNT_W-1:0] cnt_q;

    assign clr = (st_q == ST_IDLE) && start;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            idx_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) begin
                    st_q  <= ST_SAMP;
                    cnt_q <= '0;
                    lvl_q <= 1'b0;
                end
                ST_SAMP: if (cnt_q == CNT_W'(SAMPLE_CYC - 1)) begin
                    st_q  <= ST_BIT;
                    idx_q <= IDX_W'(NBITS - 1);
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
                ST_BIT: if (take) begin
                    if (idx_q == '0) begin
                        st_q  <= ST_SETL;
                        lvl_q <= 1'b1;
                        cnt_q <= '0;
                    end else begin
                        idx_q <= idx_q - 1'b1;
                    end
                end
                ST_SETL: if (cnt_q == CNT_W'(settle_cycles)) st_q <= ST_FIRE;
                         else cnt_q <= cnt_q + 1'b1;
                ST_FIRE: begin
                    st_q  <= ST_FINE;
                    cnt_q <= '0;
                end
                ST_FINE: if (cnt_q == CNT_W'(FINE_CYC - 1)) st_q <= ST_IDLE;
                         else cnt_q <= cnt_q + 1'b1;
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sar_redund_seq.sv
module sar_redund_seq
    import sar_seq_pkg::*;
#(
    parameter int NBITS      = NB_DEF,
    parameter int SAMPLE_CYC = 4,
    parameter int TO_CYC     = 6,
    parameter int FINE_CYC   = 8,
    parameter int SETTLE_W   = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [SETTLE_W-1:0] settle_cycles,
    input  logic                cmp_rdy,
    input  logic                cmp_dec,
    output logic                smp_en,
    output logic                cmp_fire,
    output logic [NBITS-1:0]    cap_p,
    output logic [NBITS-1:0]    cap_n,
    output logic [NBITS-1:0]    raw_bits,
    output logic                lvl_shift,
    output logic                fine_go,
    output logic                ct_en
);
    localparam int IDX_W = $clog2(NBITS);

    seq_st_e          st;
    logic [IDX_W-1:0] idx;
    logic             clr;
    dec_t             dec;

    sar_seq_ctrl #(
        .NBITS(NBITS), .SAMPLE_CYC(SAMPLE_CYC), .FINE_CYC(FINE_CYC), .SETTLE_W(SETTLE_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .take(dec.take),
        .settle_cycles(settle_cycles), .st_q(st), .idx_q(idx), .clr(clr), .lvl_q(lvl_shift)
    );

    sar_bit_timer #(.TO_CYC(TO_CYC)) u_tmr (
        .clk(clk), .rst(rst), .active(st == ST_BIT),
        .cmp_rdy(cmp_rdy), .cmp_dec(cmp_dec), .dec_o(dec)
    );

    sar_bit_bank #(.NBITS(NBITS)) u_bank (
        .clk(clk), .rst(rst), .clr(clr), .dec_i(dec), .idx(idx),
        .raw_q(raw_bits), .capp_q(cap_p), .capn_q(cap_n)
    );

    assign smp_en   = (st == ST_SAMP);
    assign cmp_fire = (st == ST_BIT);
    assign fine_go  = (st == ST_FIRE);
    assign ct_en    = (st == ST_SETL) || (st == ST_FIRE) || (st == ST_FINE);
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
    parameter int NBITS = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_en,
    input logic             cmp_fire,
    input logic [NBITS-1:0] cap_p,
    input logic [NBITS-1:0] cap_n,
    input logic [NBITS-1:0] raw_bits,
    input logic             lvl_shift,
    input logic             fine_go,
    input logic             ct_en
);
    a_r5_one_side: assert property (@(posedge clk) disable iff (rst)
        (cap_p & cap_n) == '0);

    a_r5_monotonic: assert property (@(posedge clk) disable iff (rst)
        !smp_en |-> (((cap_p & $past(cap_p)) == $past(cap_p)) &&
                     ((cap_n & $past(cap_n)) == $past(cap_n))));

    a_r5_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
        !smp_en |-> ($countones(cap_p | cap_n) <= $countones($past(cap_p | cap_n)) + 1));

    a_r8_ct_off: assert property (@(posedge clk) disable iff (rst)
        (smp_en || cmp_fire) |-> !ct_en);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
        fine_go |=> !fine_go);

    a_r6_lvl_with_ct: assert property (@(posedge clk) disable iff (rst)
        $rose(lvl_shift) |-> ct_en);

    a_r9_raw_hold: assert property (@(posedge clk) disable iff (rst)
        (!smp_en && !cmp_fire && $past(!smp_en && !cmp_fire)) |-> $stable(raw_bits));

    a_r1_sample_clear: assert property (@(posedge clk) disable iff (rst)
        smp_en |-> (raw_bits == '0 && cap_p == '0 && cap_n == '0 && !lvl_shift));
endmodule

bind sar_redund_seq sar_seq_chk #(.NBITS(NBITS)) u_chk (
    .clk(clk), .rst(rst), .smp_en(smp_en), .cmp_fire(cmp_fire), .cap_p(cap_p),
    .cap_n(cap_n), .raw_bits(raw_bits), .lvl_shift(lvl_shift), .fine_go(fine_go),
    .ct_en(ct_en)
);

// File: tb/sim_sar_redund_seq.sv
module sim_sar_redund_seq;
    localparam int CLK_PER = 10;
    localparam int NB      = 8;
    localparam int SCYC    = 4;
    localparam int TOC     = 6;
    localparam int FCYC    = 8;
    localparam int SW      = 4;

    logic          clk = 0;
    logic          rst = 1;
    logic          start = 0;
    logic [SW-1:0] settle_cycles = '0;
    logic          cmp_rdy = 0;
    logic          cmp_dec = 0;
    logic          smp_en, cmp_fire, lvl_shift, fine_go, ct_en;
    logic [NB-1:0] cap_p, cap_n, raw_bits;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_PER/2) clk = ~clk;

    sar_redund_seq #(
        .NBITS(NB), .SAMPLE_CYC(SCYC), .TO_CYC(TOC), .FINE_CYC(FCYC), .SETTLE_W(SW)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .settle_cycles(settle_cycles),
        .cmp_rdy(cmp_rdy), .cmp_dec(cmp_dec), .smp_en(smp_en), .cmp_fire(cmp_fire),
        .cap_p(cap_p), .cap_n(cap_n), .raw_bits(raw_bits), .lvl_shift(lvl_shift),
        .fine_go(fine_go), .ct_en(ct_en)
    );

    function automatic int wt(input int b);
        int t[8] = '{8, 16, 24, 40, 64, 128, 256, 480};
        return t[b];
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(0, "watchdog", cyc, 100000);
            summary();
        end
    end

    // dfix < 0: random reply latency per bit; poke: start pulse during bit cycles
    task automatic run_conv(input int vin, input int st, input int dfix, input bit poke);
        int r;
        int n;
        bit bad;
        logic [NB-1:0] eb;
        r  = vin;
        eb = '0;
        settle_cycles = SW'(st);
        start = 1;
        @(negedge clk);
        start = 0;
        chk(raw_bits == 0 && cap_p == 0 && cap_n == 0 && !lvl_shift, "R1 cleared",
            int'(raw_bits), 0);
        n = 0; bad = 0;
        while (smp_en) begin
            if (ct_en || cmp_fire) bad = 1;
            n++;
            @(negedge clk);
        end
        chk(n == SCYC, "R1 sample length", n, SCYC);
        chk(!bad, "R8 ct off in sample", int'(bad), 0);
        bad = 0;
        for (int b = NB - 1; b >= 0; b--) begin
            int  d;
            int  w;
            bit  bitv;
            bit  took;
            d = (dfix >= 0) ? dfix : int'($urandom_range(0, TOC + 1));
            w = 0;
            forever begin
                if (!cmp_fire || ct_en) bad = 1;
                if (poke && b == 4 && w == 0) start = 1;
                if (w == d) begin
                    cmp_rdy = 1;
                    cmp_dec = (r > 0);
                end else begin
                    cmp_rdy = 0;
                    cmp_dec = 1'($urandom_range(0, 1)); // R11 noise
                end
                took = (w == d) || (w == TOC - 1);
                bitv = (w == d) ? (r > 0) : 1'b0;
                @(negedge clk);
                cmp_rdy = 0;
                if (poke && b == 4 && w == 0) begin
                    start = 0;
                    chk(!smp_en, "R10 start ignored", int'(smp_en), 0);
                end
                if (took) break;
                w++;
            end
            eb[b] = bitv;
            r = bitv ? r - wt(b) : r + wt(b);
        end
        chk(!bad, "R2 eight bit cycles, ct off", int'(bad), 0);
        chk(raw_bits == eb, "R3 R4 R11 raw bits", int'(raw_bits), int'(eb));
        chk(cap_p == eb, "R3 positive switches", int'(cap_p), int'(eb));
        chk(cap_n == ~eb, "R5 negative switches", int'(cap_n), int'(~eb));
        chk(lvl_shift && ct_en && !cmp_fire, "R6 level shift and ct on",
            int'({lvl_shift, ct_en}), 3);
        n = 0; bad = 0;
        while (!fine_go) begin
            if (!ct_en || !lvl_shift) bad = 1;
            n++;
            @(negedge clk);
        end
        chk(n == st + 1, "R7 settle length", n, st + 1);
        chk(!bad, "R6 held through settle", int'(bad), 0);
        @(negedge clk);
        chk(!fine_go, "R7 one-cycle pulse", int'(fine_go), 0);
        n = 0;
        while (ct_en) begin
            n++;
            @(negedge clk);
        end
        chk(n == FCYC, "R8 fine window", n, FCYC);
        cmp_rdy = 1; cmp_dec = 1;
        repeat (3) @(negedge clk);
        cmp_rdy = 0;
        chk(raw_bits == eb && lvl_shift && !ct_en, "R9 raw held while idle",
            int'(raw_bits), int'(eb));
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(!smp_en && !cmp_fire && !ct_en && !fine_go && !lvl_shift, "R1 reset outputs",
            int'({smp_en, cmp_fire, ct_en, fine_go, lvl_shift}), 0);
        chk(raw_bits == 0 && cap_p == 0 && cap_n == 0, "R1 reset bits", int'(raw_bits), 0);
        run_conv(1000, 3, 0, 0);          // positive full scale, dec=1 path
        run_conv(-1000, 0, 0, 0);         // negative full scale, settle 0
        run_conv(0, 15, 1, 0);            // zero input, max settle
        run_conv(500, 2, TOC + 1, 0);     // R4 all timeouts
        run_conv(-300, 1, TOC - 1, 0);    // R4 reply in last allowed cycle
        run_conv(123, 4, -1, 1);          // R10 start mid-conversion
        for (int k = 0; k < 20; k++) begin
            run_conv(int'($urandom_range(0, 2000)) - 1000,
                     int'($urandom_range(0, 15)), -1, 0);
        end
        summary();
    end
endmodule